// File: doc/BRIEF.md
# Static-Prediction Branch Execute Stage

This stage takes one branch per cycle from dispatch and works out where it goes. It computes the target address, either relative to the branch's own address or from a register-supplied value. For a conditional branch it also checks whether the integer side has already resolved the condition. Unconditional branches, and conditional branches already resolved as taken, fold the instruction queue behind the branch and redirect fetch to the target. Unresolved conditional branches get a static guess. A backward relative conditional branch is guessed taken and everything else not taken. A hint bit in the branch's option field flips that guess. A taken guess redirects fetch at once. The branch is then passed to a recovery stage with its guess and the address to fetch if the guess is wrong.

Branches that are not passed to recovery and that update the link or count register go to a writeback stage. A branch is accepted on the clock edge where `in_valid` and `in_ready` are both high. During the next cycle the stage makes its decisions and drives combinational fold, redirect and hand-off pulses. The consumers take these pulses at the edge that ends that cycle.

The controller has three states. `ST_IDLE` means the stage is empty. `ST_EXEC` means a branch was loaded at the last edge and is being acted on. `ST_STALL` means an unresolved branch is held because the recovery stage is busy.

The transitions are:
- load: `ST_IDLE` to `ST_EXEC`.
- done-and-load: `ST_EXEC` or `ST_STALL` to `ST_EXEC`.
- done-empty: `ST_EXEC` or `ST_STALL` to `ST_IDLE`.
- block: `ST_EXEC` or `ST_STALL` to `ST_STALL`, taken when the branch is unresolved and `rec_busy` is high.

Top module: `brx_stage`

## Requirements
- R1: After reset the stage is empty. `in_ready` is 1 and `fold`, `fetch_redir`, `rec_valid` and `wb_valid` are 0.
- R2: Branch kind encodings on `in_kind` are 0 = unconditional relative, 1 = conditional relative, 2 = conditional to register, 3 = unconditional to register. Relative kinds target `pc + (sign-extended in_disp << 2)`. Register kinds target `in_regt` with bits [1:0] cleared. Every redirect address has bits [1:0] equal to 0.
- R3: An unconditional branch asserts `fold` and `fetch_redir` for one cycle with `fetch_addr` equal to the target, and it never asserts `rec_valid`.
- R4: A conditional branch with `res_known`=1 redirects to the target when `res_taken`=1 and does not redirect when `res_taken`=0. In neither case is it sent to recovery.
- R5: For an unresolved conditional branch with hint 0, the guess is taken only for kind 1 with a negative displacement (bit DW-1 set). Kind 2 is guessed not taken.
- R6: `in_hint`=1 inverts the guess of R5.
- R7: An unresolved conditional branch asserts `rec_valid` with `rec_pred` equal to the guess. `rec_alt` is `pc+4` when the guess is taken and the target when it is not. `fold`/`fetch_redir` follow the guess.
- R8: A branch not sent to recovery asserts `wb_valid` exactly when it updates LR or CTR, with `wb_lr`/`wb_ctr` copying the flags. A branch sent to recovery never asserts `wb_valid`.
- R9: While an unresolved branch is held and `rec_busy` is 1, `in_ready` is 0 and no fold, redirect or hand-off is driven. The branch completes in the first cycle where `rec_busy` drops or its condition resolves.
- R10: A branch is acted on in exactly one cycle. `in_ready` is 1 in that cycle, so back-to-back branches are accepted with one-per-cycle throughput.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Branch offered |
| in_ready | output | 1 | Stage can accept a branch this cycle |
| in_kind | input | 2 | Branch kind (see R2) |
| in_pc | input | AW | Address of the branch |
| in_disp | input | DW | Word displacement for relative kinds |
| in_regt | input | AW | Register target for register kinds |
| in_hint | input | 1 | Prediction inversion hint |
| in_upd_lr | input | 1 | Branch updates link register |
| in_upd_ctr | input | 1 | Branch updates count register |
| res_known | input | 1 | Condition of the branch in the stage is resolved |
| res_taken | input | 1 | Resolved condition outcome |
| rec_busy | input | 1 | Recovery stage occupied |
| cur_pc | output | AW | Address of the branch being acted on |
| fold | output | 1 | Discard queue entries after the branch |
| fetch_redir | output | 1 | Redirect fetch |
| fetch_addr | output | AW | Redirect address |
| rec_valid | output | 1 | Hand-off to recovery stage |
| rec_pred | output | 1 | Guessed direction |
| rec_alt | output | AW | Address to fetch on misprediction |
| wb_valid | output | 1 | Hand-off to writeback stage |
| wb_lr | output | 1 | Writeback updates link register |
| wb_ctr | output | 1 | Writeback updates count register |

## Verification
The assertions check several properties on every cycle. A recovery hand-off never happens while the recovery stage is busy. Recovery and writeback hand-offs never occur together. Redirect addresses stay word aligned. Any completed branch leaves the stage ready. An idle stage stays quiet. A held branch keeps its address. Only the bench scenarios can show that the guess follows the backward-displacement rule and its hint inversion. They also show that the alternate address picks the right side and that stalls release correctly when the recovery stage frees or the condition resolves.

// File: rtl/brx_pkg.sv
package brx_pkg;

    typedef enum logic [1:0] {
        BK_JUMP     = 2'd0,
        BK_COND_REL = 2'd1,
        BK_COND_REG = 2'd2,
        BK_JUMP_REG = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_STALL = 2'd2
    } brx_state_e;

    function automatic logic kind_is_cond(br_kind_e k);
        return (k == BK_COND_REL) || (k == BK_COND_REG);
    endfunction

    function automatic logic kind_is_reg(br_kind_e k);
        return (k == BK_COND_REG) || (k == BK_JUMP_REG);
    endfunction

endpackage

// File: rtl/brx_addr.sv
module brx_addr
    import brx_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 24
) (
    input  br_kind_e        kind,
    input  logic [AW-1:0]   pc,
    input  logic [DW-1:0]   disp,
    input  logic [AW-1:0]   regt,
    output logic [AW-1:0]   target,
    output logic [AW-1:0]   fallthru
);
    localparam int EXT = AW - DW - 2;

    logic [AW-1:0] offset;

    generate
        if (EXT > 0) begin : g_ext
            assign offset = {{EXT{disp[DW-1]}}, disp, 2'b00};
        end else begin : g_trunc
            logic [DW+1:0] wide;
            assign wide   = {disp, 2'b00};
            assign offset = wide[AW-1:0];
        end
    endgenerate

    always_comb begin
        if (kind_is_reg(kind)) begin
            target = {regt[AW-1:2], 2'b00};
        end else begin
            target = {pc[AW-1:2], 2'b00} + offset;
        end
        fallthru = {pc[AW-1:2], 2'b00} + AW'(4);
    end
endmodule

// File: rtl/brx_predict.sv
module brx_predict
    import brx_pkg::*;
(
    input  br_kind_e kind,
    input  logic     disp_neg,
    input  logic     hint,
    output logic     guess_taken
);
    logic base;

    always_comb begin
        base        = (kind == BK_COND_REL) && disp_neg;
        guess_taken = base ^ hint;
    end
endmodule

// File: rtl/brx_ctrl.sv
module brx_ctrl
    import brx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic unresolved,
    input  logic rec_busy,
    output logic in_ready,
    output logic load,
    output logic act,
    output logic held
);
    brx_state_e state, state_nx;
    logic busy_slot;

    always_comb begin
        busy_slot = (state != ST_IDLE);
        act       = busy_slot && !(unresolved && rec_busy);
        held      = busy_slot && !act;
        in_ready  = !busy_slot || act;
        load      = in_valid && in_ready;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:            state_nx = load ? ST_EXEC : ST_IDLE;
            ST_EXEC, ST_STALL:  state_nx = act ? (load ? ST_EXEC : ST_IDLE) : ST_STALL;
            default:            state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (in_ready && !act));

    p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && rec_busy && unresolved) |-> !in_ready);
endmodule

// File: rtl/brx_stage.sv
module brx_stage
    import brx_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [1:0]      in_kind,
    input  logic [AW-1:0]   in_pc,
    input  logic [DW-1:0]   in_disp,
    input  logic [AW-1:0]   in_regt,
    input  logic            in_hint,
    input  logic            in_upd_lr,
    input  logic            in_upd_ctr,
    input  logic            res_known,
    input  logic            res_taken,
    input  logic            rec_busy,
    output logic [AW-1:0]   cur_pc,
    output logic            fold,
    output logic            fetch_redir,
    output logic [AW-1:0]   fetch_addr,
    output logic            rec_valid,
    output logic            rec_pred,
    output logic [AW-1:0]   rec_alt,
    output logic            wb_valid,
    output logic            wb_lr,
    output logic            wb_ctr
);
    br_kind_e      kind_q;
    logic [AW-1:0] pc_q, regt_q;
    logic [DW-1:0] disp_q;
    logic          hint_q, lr_q, ctr_q;

    logic          load, act, held, unresolved, guess, taken_now;
    logic [AW-1:0] target, fallthru;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= BK_JUMP;
            pc_q   <= '0;
            regt_q <= '0;
            disp_q <= '0;
            hint_q <= 1'b0;
            lr_q   <= 1'b0;
            ctr_q  <= 1'b0;
        end else if (load) begin
            kind_q <= br_kind_e'(in_kind);
            pc_q   <= in_pc;
            regt_q <= in_regt;
            disp_q <= in_disp;
            hint_q <= in_hint;
            lr_q   <= in_upd_lr;
            ctr_q  <= in_upd_ctr;
        end
    end

    assign unresolved = kind_is_cond(kind_q) && !res_known;

    brx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .unresolved (unresolved),
        .rec_busy   (rec_busy),
        .in_ready   (in_ready),
        .load       (load),
        .act        (act),
        .held       (held)
    );

    brx_addr #(.AW(AW), .DW(DW)) u_addr (
        .kind     (kind_q),
        .pc       (pc_q),
        .disp     (disp_q),
        .regt     (regt_q),
        .target   (target),
        .fallthru (fallthru)
    );

    brx_predict u_pred (
        .kind        (kind_q),
        .disp_neg    (disp_q[DW-1]),
        .hint        (hint_q),
        .guess_taken (guess)
    );

    always_comb begin
        taken_now   = unresolved ? guess : (!kind_is_cond(kind_q) || res_taken);
        cur_pc      = pc_q;
        fold        = act && taken_now;
        fetch_redir = act && taken_now;
        fetch_addr  = target;
        rec_valid   = act && unresolved;
        rec_pred    = guess;
        rec_alt     = guess ? fallthru : target;
        wb_valid    = act && !unresolved && (lr_q || ctr_q);
        wb_lr       = lr_q;
        wb_ctr      = ctr_q;
    end

    p_no_rec_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !rec_busy);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(pc_q));

    p_rec_wb_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_valid && wb_valid));

    p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_redir |-> (fetch_addr[1:0] == 2'b00));

    p_ready_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid || wb_valid || fetch_redir) |-> in_ready);
endmodule

// File: tb/sim_brx_stage.sv
module sim_brx_stage;
    localparam int AW = 32;
    localparam int DW = 24;

    typedef struct packed {
        logic [1:0]    kind;
        logic [31:0]   pc;
        logic [23:0]   disp;
        logic [31:0]   regt;
        logic          hint;
        logic          known;
        logic          rtaken;
        logic          lr;
        logic          ctr;
        logic          e_redir;
        logic          e_rec;
        logic          e_wb;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{2'd0, 32'h1000, 24'h000004, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'd0, 32'h1000, 24'hFFFFF8, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{2'd1, 32'h2000, 24'h000010, 32'h0,    1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'd1, 32'h2000, 24'h000010, 32'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{2'd1, 32'h3000, 24'hFFFFF0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{2'd1, 32'h3000, 24'h000020, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd1, 32'h3000, 24'hFFFFF0, 32'h0,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd1, 32'h3000, 24'h000020, 32'h0,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{2'd2, 32'h4000, 24'h0,      32'h8003, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd2, 32'h4000, 24'h0,      32'h8003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{2'd3, 32'h5000, 24'h0,      32'h9ABC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_hint = 1'b0, in_upd_lr = 1'b0, in_upd_ctr = 1'b0;
    logic res_known = 1'b0, res_taken = 1'b0, rec_busy = 1'b0;
    logic [1:0] in_kind = 2'd0;
    logic [AW-1:0] in_pc = '0, in_regt = '0;
    logic [DW-1:0] in_disp = '0;
    logic in_ready, fold, fetch_redir, rec_valid, rec_pred, wb_valid, wb_lr, wb_ctr;
    logic [AW-1:0] cur_pc, fetch_addr, rec_alt;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    brx_stage #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_pc(in_pc), .in_disp(in_disp), .in_regt(in_regt),
        .in_hint(in_hint), .in_upd_lr(in_upd_lr), .in_upd_ctr(in_upd_ctr),
        .res_known(res_known), .res_taken(res_taken), .rec_busy(rec_busy),
        .cur_pc(cur_pc), .fold(fold), .fetch_redir(fetch_redir), .fetch_addr(fetch_addr),
        .rec_valid(rec_valid), .rec_pred(rec_pred), .rec_alt(rec_alt),
        .wb_valid(wb_valid), .wb_lr(wb_lr), .wb_ctr(wb_ctr)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] tgt(vec_t v);
        if (v.kind[1]) return {v.regt[31:2], 2'b00};
        return v.pc + {{6{v.disp[23]}}, v.disp, 2'b00};
    endfunction

    task automatic drive(vec_t v);
        in_kind = v.kind; in_pc = v.pc; in_disp = v.disp; in_regt = v.regt;
        in_hint = v.hint; in_upd_lr = v.lr; in_upd_ctr = v.ctr;
        res_known = v.known; res_taken = v.rtaken;
        in_valid = 1'b1;
    endtask

    task automatic check_vec(vec_t v, int i);
        logic [31:0] t;
        t = tgt(v);
        chk($sformatf("R3/R4/R5/R6 redirect v%0d", i), {31'd0, fetch_redir}, {31'd0, v.e_redir});
        chk($sformatf("R3 fold v%0d", i), {31'd0, fold}, {31'd0, v.e_redir});
        if (v.e_redir) chk($sformatf("R2 target v%0d", i), fetch_addr, t);
        chk($sformatf("R7 rec_valid v%0d", i), {31'd0, rec_valid}, {31'd0, v.e_rec});
        if (v.e_rec) begin
            chk($sformatf("R7 rec_pred v%0d", i), {31'd0, rec_pred}, {31'd0, v.e_redir});
            chk($sformatf("R7 rec_alt v%0d", i), rec_alt, v.e_redir ? v.pc + 32'd4 : t);
        end
        chk($sformatf("R8 wb_valid v%0d", i), {31'd0, wb_valid}, {31'd0, v.e_wb});
        if (v.e_wb) chk($sformatf("R8 wb_lr v%0d", i), {31'd0, wb_lr}, {31'd0, v.lr});
        chk($sformatf("R10 ready v%0d", i), {31'd0, in_ready}, 32'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        vec_t a;
        vec_t b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ready", {31'd0, in_ready}, 32'd1);
        chk("R1 quiet", {28'd0, fold, fetch_redir, rec_valid, wb_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i]);
            @(posedge clk);
            #1 in_valid = 1'b0;
            @(negedge clk);
            check_vec(VT[i], i);
        end
        @(negedge clk);
        chk("R10 single cycle action", {30'd0, fetch_redir, rec_valid}, 32'd0);

        // R9: stall while recovery busy, release when it frees
        a = VT[4];
        @(negedge clk);
        rec_busy = 1'b1;
        drive(a);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        chk("R9 stall ready", {31'd0, in_ready}, 32'd0);
        chk("R9 stall quiet", {29'd0, fold, fetch_redir, rec_valid}, 32'd0);
        @(negedge clk);
        chk("R9 still held", {31'd0, rec_valid}, 32'd0);
        chk("R9 held pc", cur_pc, a.pc);
        rec_busy = 1'b0;
        #1;
        chk("R9 release rec", {31'd0, rec_valid}, 32'd1);
        chk("R9 release redirect", {31'd0, fetch_redir}, 32'd1);
        chk("R9 release ready", {31'd0, in_ready}, 32'd1);

        // R9: stall released by resolution instead
        @(negedge clk);
        rec_busy = 1'b1;
        drive(VT[5]);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        chk("R9 stall2 quiet", {31'd0, fetch_redir}, 32'd0);
        res_known = 1'b1;
        res_taken = 1'b1;
        #1;
        chk("R9 resolved redirect", {31'd0, fetch_redir}, 32'd1);
        chk("R9 resolved no rec", {31'd0, rec_valid}, 32'd0);
        chk("R2 resolved target", fetch_addr, tgt(VT[5]));
        @(negedge clk);
        rec_busy = 1'b0;

        // R10: back-to-back acceptance
        a = VT[0];
        b = VT[3];
        drive(a);
        @(posedge clk);
        #1 drive(b);
        @(negedge clk);
        chk("R10 first redirect", fetch_addr, tgt(a));
        chk("R10 ready while acting", {31'd0, in_ready}, 32'd1);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        chk("R10 second pc", cur_pc, b.pc);
        chk("R8 second wb", {31'd0, wb_valid}, 32'd1);
        chk("R4 second no redirect", {31'd0, fetch_redir}, 32'd0);

        // R8: count-register update via writeback
        a = VT[2];
        a.ctr = 1'b1;
        @(negedge clk);
        drive(a);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        chk("R8 ctr wb", {30'd0, wb_valid, wb_ctr}, 32'd3);

        // R8: forwarded branch with ctr update gives no writeback
        a = VT[6];
        a.ctr = 1'b1;
        @(negedge clk);
        drive(a);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        chk("R8 forwarded no wb", {30'd0, wb_valid, rec_valid}, 32'd1);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule